// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a 256-byte serial memory. It watches an oversampled two-wire bus (clock line and data line), filters and synchronizes both lines into the system clock domain, and finds START and STOP conditions. After a START it shifts in a select byte and compares its upper seven bits with a fixed identifier. It acknowledges a match by pulling the data line low through an active-low output enable.

One 8-bit pointer serves both directions and wraps from the top of memory to zero. In the write direction, the first byte after the select byte loads the pointer. Each later byte is handed to a separate programming controller as an address/data strobe. A STOP that follows at least one data byte raises a one-cycle commit pulse. In the read direction, bytes come from a synchronous read port at the pointer. A master ACK asks for the next byte and a NOACK ends the transfer. A random read is a write that carries only an address, followed by a repeated START with the read bit set.

While the programming controller reports busy, the slave does not react to a START. The master can therefore poll for the end of programming by repeating the select byte until it is acknowledged.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the output enable is low, no write strobe, commit pulse or read request is active, and the pointer holds 0.
- R2: A START (data line falls while the clock line is high), followed by a select byte sent MSB first whose upper seven bits are 1010000b, is acknowledged: the data line reads 0 during the ninth clock high phase. Bit 0 of the select byte is the direction (1 = read, 0 = write).
- R3: A select byte with any other identifier gets no acknowledge. Every byte clocked after it, up to the next START, is ignored: no ACK and no write strobe.
- R4: In a write, the byte after the select byte loads the pointer. Each further byte is acknowledged and produces one write strobe carrying the pointer and the byte, after which the pointer increments.
- R5: A STOP (data line rises while the clock line is high) after at least one written data byte produces exactly one commit pulse. A write that carries only an address produces none.
- R6: A read select returns the byte stored at the pointer, MSB first, and then increments the pointer.
- R7: A repeated START after an address-only write switches to reading, starting at the loaded address.
- R8: Each master ACK on the ninth clock of a read byte makes the slave send the next byte. The pointer wraps from 255 to 0.
- R9: A master NOACK makes the slave release the data line and return to standby. A later read continues at the following address.
- R10: While the busy input is high, a START and select byte are ignored and no ACK is given. Once busy falls, the same select byte is acknowledged.
- R11: The output enable is only asserted while the filtered clock line is low.
- R12: A clock-line pulse shorter than the filter length does not count as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| busy_i | input | 1 | Programming cycle in progress |
| mem_addr | output | 8 | Read port address (the shared pointer) |
| mem_rd_en | output | 1 | Read request; data is expected one clock later |
| mem_rd_data | input | 8 | Read port data |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Address of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |
| wr_end | output | 1 | One-cycle commit pulse at STOP after written data |

## Verification
The hardest situation to reach is the pointer wrap inside a sequential read. It is set up with a random read whose address-only write loads 254. A repeated START follows, and three master ACKs carry the stream across 255 into 0 and 1. The busy-poll case is reached by raising busy between transfers and repeating the same select byte before and after it falls. The filter case is reached by cutting a one-cycle low pulse into the clock high phase of a data bit, then checking that the stored byte is unchanged.

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int         AW       = 8,
  parameter int         FILT_LEN = 3,
  parameter logic [6:0] DEV_ID   = 7'b1010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          busy_i,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  input  logic [7:0]    mem_rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_end
);
  localparam int CW = $clog2(FILT_LEN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_f, sda_f, scl_d, sda_d;
  logic [CW-1:0] scl_cnt, sda_cnt;
  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, tx;
  logic [AW-1:0] ptr;
  logic          ld_tx, mack, wrote;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; scl_f <= 1'b1; scl_cnt <= '0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      if (scl_sy[1] != scl_f) begin
        if (scl_cnt == CW'(FILT_LEN - 1)) begin
          scl_f <= scl_sy[1]; scl_cnt <= '0;
        end else scl_cnt <= scl_cnt + 1'b1;
      end else scl_cnt <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_sy <= 2'b11; sda_f <= 1'b1; sda_cnt <= '0;
    end else begin
      sda_sy <= {sda_sy[0], sda_i};
      if (sda_sy[1] != sda_f) begin
        if (sda_cnt == CW'(FILT_LEN - 1)) begin
          sda_f <= sda_sy[1]; sda_cnt <= '0;
        end else sda_cnt <= sda_cnt + 1'b1;
      end else sda_cnt <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f; sda_d <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;
  wire byte_end = (bitcnt == 4'd8);

  assign mem_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      sda_oe <= 1'b0; mem_rd_en <= 1'b0; ld_tx <= 1'b0; mack <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_end <= 1'b0;
      wrote <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      wr_valid  <= 1'b0;
      wr_end    <= 1'b0;
      ld_tx     <= mem_rd_en;
      if (ld_tx) tx <= mem_rd_data;
      if (mem_rd_en) ptr <= ptr + 1'b1;
      if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        wr_end <= wrote; wrote <= 1'b0;
      end else if (start_c && !busy_i) begin
        st <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0; wrote <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_DEV, S_ADDR, S_WDAT: begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end
          S_RDAT: bitcnt <= bitcnt + 1'b1;
          S_RACK: begin
            mack <= ~sda_f;
            if (!sda_f) mem_rd_en <= 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_DEV: if (byte_end) begin
            if (shreg[7:1] == DEV_ID) begin
              st <= S_DACK; sda_oe <= 1'b1;
              if (shreg[0]) mem_rd_en <= 1'b1;
            end else st <= S_IDLE;
          end
          S_ADDR: if (byte_end) begin
            st <= S_AACK; sda_oe <= 1'b1; ptr <= shreg[AW-1:0];
          end
          S_WDAT: if (byte_end) begin
            st <= S_WACK; sda_oe <= 1'b1; wrote <= 1'b1;
            wr_valid <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
            ptr <= ptr + 1'b1;
          end
          S_DACK: begin
            bitcnt <= '0;
            if (shreg[0]) begin
              st <= S_RDAT; sda_oe <= ~tx[7];
            end else begin
              st <= S_ADDR; sda_oe <= 1'b0;
            end
          end
          S_AACK, S_WACK: begin
            st <= S_WDAT; bitcnt <= '0; sda_oe <= 1'b0;
          end
          S_RDAT: begin
            if (byte_end) begin
              st <= S_RACK; sda_oe <= 1'b0;
            end else begin
              sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
            end
          end
          S_RACK: begin
            bitcnt <= '0;
            if (mack) begin
              st <= S_RDAT; sda_oe <= ~tx[7];
            end else begin
              st <= S_IDLE; sda_oe <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end

  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_f);

  assert_ack_only_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DACK && sda_oe) |-> (shreg[7:1] == DEV_ID));

  assert_busy_holds_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && busy_i && !stop_c) |=> (st == S_IDLE));

  assert_read_advances_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (ptr == $past(ptr) + 1'b1));

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, mem_rd_en, wr_end}));

  assert_commit_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |-> $past(wrote));
endmodule

// File: tb/test_tw_mem_slave.sv
module test_tw_mem_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 12;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic       sda_oe, mem_rd_en, wr_valid, wr_end;
  logic [7:0] mem_addr, wr_addr, wr_data;
  logic [7:0] mem_rd_data = 8'h00;
  logic [7:0] mem [256];
  logic [7:0] wa [64];
  logic [7:0] wd [64];
  int         wn = 0, ends = 0, oe_viol = 0, checks = 0, errors = 0, cyc = 0;
  wire        sda_line = m_sda & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  tw_mem_slave i_tw_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy_i(busy), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rd_data(mem_rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_end(wr_end));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    if (wr_valid) begin
      mem[wr_addr] <= wr_data;
      if (wn < 64) begin wa[wn] <= wr_addr; wd[wn] <= wr_data; end
      wn <= wn + 1;
    end
    if (wr_end) ends <= ends + 1;
  end

  logic oe_q = 1'b0;
  always @(negedge clk) begin
    if (sda_oe && !oe_q && m_scl) oe_viol++;
    oe_q = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, input bit glitch, output logic s);
    m_sda = b; wt(Q);
    m_scl = 1'b1; wt(Q/2);
    if (glitch) begin m_scl = 1'b0; wt(1); m_scl = 1'b1; end
    wt(Q/2); s = sda_line; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch && i == 4, s);
    clk_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, 1'b0, s); d = {d[6:0], s}; end
    clk_bit(~give_ack, 1'b0, s);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
    chk(!wr_valid && !wr_end && !mem_rd_en, "R1 strobes", {wr_valid, wr_end, mem_rd_en}, 0);
    chk(mem_addr == 8'h00, "R1 pointer", mem_addr, 0);
  endtask

  task automatic t_write();
    bit a; int w0 = wn, e0 = ends;
    bus_start();
    send_byte(8'hA0, 0, a); chk(a, "R2 select ack", a, 1);
    send_byte(8'h10, 0, a); chk(a, "R4 addr ack", a, 1);
    send_byte(8'h3C, 0, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'hC3, 0, a);
    send_byte(8'h99, 0, a); chk(a, "R4 data ack last", a, 1);
    bus_stop(); wt(4);
    chk(wn == w0 + 3, "R4 strobe count", wn - w0, 3);
    chk(wa[w0] == 8'h10 && wd[w0] == 8'h3C, "R4 byte0", {wa[w0], wd[w0]}, 16'h103C);
    chk(wa[w0+2] == 8'h12 && wd[w0+2] == 8'h99, "R4 byte2", {wa[w0+2], wd[w0+2]}, 16'h1299);
    chk(ends == e0 + 1, "R5 commit", ends - e0, 1);
  endtask

  task automatic t_cur_read();
    bit a; logic [7:0] d;
    bus_start();
    send_byte(8'hA1, 0, a); chk(a, "R6 read select ack", a, 1);
    read_byte(0, d); chk(d == mem[8'h13], "R6 current read", d, mem[8'h13]);
    chk(sda_oe == 1'b0, "R9 released after noack", sda_oe, 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, 0, a); read_byte(0, d); bus_stop();
    chk(d == mem[8'h14], "R9 next read continues", d, mem[8'h14]);
  endtask

  task automatic t_random();
    bit a; logic [7:0] d; int e0 = ends;
    bus_start(); send_byte(8'hA0, 0, a); send_byte(8'h40, 0, a);
    chk(a, "R7 addr ack", a, 1);
    bus_start(); send_byte(8'hA1, 0, a); chk(a, "R7 reselect ack", a, 1);
    read_byte(0, d); bus_stop(); wt(4);
    chk(d == mem[8'h40], "R7 random read", d, mem[8'h40]);
    chk(ends == e0, "R5 no commit for address only", ends - e0, 0);
  endtask

  task automatic t_seq_wrap();
    bit a; logic [7:0] d;
    bus_start(); send_byte(8'hA0, 0, a); send_byte(8'hFE, 0, a);
    bus_start(); send_byte(8'hA1, 0, a);
    for (int i = 0; i < 4; i++) begin
      read_byte(i != 3, d);
      chk(d == mem[8'(8'hFE + i)], "R8 sequential wrap", d, mem[8'(8'hFE + i)]);
    end
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a; int w0 = wn;
    bus_start();
    send_byte(8'hA2, 0, a); chk(!a, "R3 mismatch no ack", a, 0);
    send_byte(8'h20, 0, a); chk(!a, "R3 later byte no ack", a, 0);
    send_byte(8'h55, 0, a); bus_stop(); wt(4);
    chk(wn == w0, "R3 no write strobe", wn - w0, 0);
  endtask

  task automatic t_busy();
    bit a; int w0 = wn;
    busy = 1'b1;
    bus_start(); send_byte(8'hA0, 0, a); chk(!a, "R10 busy no ack", a, 0);
    send_byte(8'h00, 0, a); send_byte(8'h77, 0, a); bus_stop(); wt(4);
    chk(wn == w0, "R10 busy no write", wn - w0, 0);
    busy = 1'b0;
    bus_start(); send_byte(8'hA0, 0, a); chk(a, "R10 ack after busy", a, 1);
    bus_stop();
  endtask

  task automatic t_glitch();
    bit a; logic [7:0] d; int w0 = wn;
    bus_start(); send_byte(8'hA0, 0, a); send_byte(8'h80, 0, a);
    send_byte(8'hA5, 1, a); chk(a, "R12 ack with glitch", a, 1);
    bus_stop(); wt(4);
    chk(wn == w0 + 1 && wd[w0] == 8'hA5, "R12 data intact", wd[w0], 8'hA5);
    bus_start(); send_byte(8'hA0, 0, a); send_byte(8'h80, 0, a);
    bus_start(); send_byte(8'hA1, 0, a); read_byte(0, d); bus_stop();
    chk(d == 8'hA5, "R12 readback", d, 8'hA5);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_write();
    t_cur_read();
    t_random();
    t_seq_wrap();
    t_mismatch();
    t_busy();
    t_glitch();
    chk(oe_viol == 0, "R11 oe rises with clock low", oe_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule